// File: doc/BRIEF.md
# Configuration Memory Test Access Port

This block is the boundary-scan test access port of a configuration memory device. A 16-state controller runs on the test clock and the mode-select input. It places an 8-bit instruction register or one of several data registers between the serial input and the serial output. The data registers are a 1-bit bypass stage, a fixed 32-bit identification word, a 32-bit user code and a small boundary chain. The chain covers the device's output pins and input pins.

When the instruction register is captured, it shows two device status bits: in-system-programming active and read-protection set. Beyond the usual test instructions, the block has a configure instruction. It pulls an active-low configure-request line low for a fixed number of test clocks, so that a downstream programmable device starts loading its configuration. The flash array, the programming algorithm and erase sit outside this block. Only their status bits come in.

Top module: `cfg_mem_tap`

## Requirements
- R1: The controller follows the standard 16-state test access port graph on rising edges of `tck`. `trst_n` low forces Test-Logic-Reset at once. Five rising edges with `tms`=1 reach Test-Logic-Reset from any state.
- R2: The instruction register is 8 bits. It shifts least significant bit first, with `tdi` entering bit 7. Capture loads bits 7..0 = 0,0,0,`isp_active`,`secure_set`,0,0,1.
- R3: Opcodes are EXTEST=00h, SAMPLE/PRELOAD=01h, CLAMP=FAh, HIGHZ=FCh, USERCODE=FDh, IDCODE=FEh, BYPASS=FFh and CONFIG=EEh. BYPASS, CLAMP, HIGHZ, CONFIG and every unlisted code select a 1-bit bypass register that captures 0.
- R4: Test-Logic-Reset, whether reached through `tms` or through `trst_n`, makes IDCODE the current instruction.
- R5: IDCODE selects a 32-bit register that captures {VERSION[3:0], FAMILY[7:0], PRODUCT[7:0], COMPANY[10:0], 1}, from bit 31 down to bit 0.
- R6: USERCODE selects a 32-bit register that captures `user_code` when `user_code_vld`=1 and captures FFFFFFFFh otherwise.
- R7: EXTEST and SAMPLE/PRELOAD select a boundary chain of 2·N_OUT+N_IN cells. Output pin j has its enable cell at bit 2j and its data cell at bit 2j+1, so the data cell is nearer `tdi`. Input pin k sits at bit 2·N_OUT+k. Capture samples the pin values. The update register changes only on Update-DR.
- R8: Under EXTEST and CLAMP, `pad_out[j]` and `pad_oe[j]` come from update bits 2j+1 and 2j. Under every other instruction except HIGHZ, they follow `core_out` and `core_oe`.
- R9: Under HIGHZ, every bit of `pad_oe` is 0.
- R10: An Update-IR that loads CONFIG drives `cfg_req_n` low for exactly PULSE_CYCLES rising `tck` edges, starting with that Update-IR edge. Otherwise the line is high, and `trst_n` releases it at once.
- R11: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is 1 only in Shift-IR and Shift-DR, and is 0 after reset.
- R12: Every data register shifts least significant bit first, with `tdi` entering its most significant bit. A scan of length+1 bits returns the captured value and then the first `tdi` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select |
| tdi | input | 1 | Serial data in |
| isp_active | input | 1 | Programming-in-progress status |
| secure_set | input | 1 | Read-protection status |
| user_code_vld | input | 1 | User code has been programmed |
| user_code | input | 32 | Programmed user code |
| core_out | input | N_OUT | Functional output values |
| core_oe | input | N_OUT | Functional output enables |
| pad_in | input | N_IN | Values seen on input pins |
| pad_out | output | N_OUT | Values driven to output pins |
| pad_oe | output | N_OUT | Output pin enables |
| tdo | output | 1 | Serial data out |
| tdo_oe | output | 1 | Serial output enable |
| cfg_req_n | output | 1 | Configure request, active low |

## Verification
The bench builds the block with N_OUT=3, N_IN=2 and PULSE_CYCLES=5. With these values the 8-bit boundary chain and the configure pulse are short enough to sweep every one of the 256 opcodes through a full IR scan and a full DR scan. Each sweep step checks the register length, the captured value, the pad drive and the configure line against values computed in the bench. The status inputs and the user-code-valid input are taken from opcode bits, so every capture pattern combination turns up during the sweep.

// File: rtl/tap_pkg.sv
package tap_pkg;

   localparam int IR_W = 8;
   localparam int WORD_W = 32;

   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
   } tap_state_t;

   typedef enum logic [1:0] {
      DR_BYPASS, DR_IDENT, DR_USER, DR_CHAIN
   } dr_sel_t;

   localparam logic [IR_W-1:0] OP_EXTEST   = 8'h00;
   localparam logic [IR_W-1:0] OP_SAMPLE   = 8'h01;
   localparam logic [IR_W-1:0] OP_CLAMP    = 8'hFA;
   localparam logic [IR_W-1:0] OP_HIGHZ    = 8'hFC;
   localparam logic [IR_W-1:0] OP_USERCODE = 8'hFD;
   localparam logic [IR_W-1:0] OP_IDCODE   = 8'hFE;
   localparam logic [IR_W-1:0] OP_BYPASS   = 8'hFF;
   localparam logic [IR_W-1:0] OP_CONFIG   = 8'hEE;

   function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
      case (s)
         ST_RESET:  return m ? ST_RESET  : ST_IDLE;
         ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
         default:   return m ? ST_SEL_DR : ST_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_t state
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= ST_RESET;
      else         state <= tap_next(state, tms);
   end

   // R1
   hold_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_RESET && tms) |=> (state == ST_RESET));

   // R1
   shift_dr_entry_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_SH_DR) |-> ($past(state) == ST_CAP_DR || $past(state) == ST_SH_DR ||
                               $past(state) == ST_EX2_DR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import tap_pkg::*;
(
   input  logic            tck,
   input  logic            trst_n,
   input  tap_state_t      state,
   input  logic            tdi,
   input  logic            isp_active,
   input  logic            secure_set,
   output logic [IR_W-1:0] ir_shift,
   output logic [IR_W-1:0] ir
);

   logic [IR_W-1:0] cap_pat;

   initial begin : ir_width_chk
      assert (IR_W == 8) else $error("instruction register must be 8 bits");
   end

   assign cap_pat = {3'b000, isp_active, secure_set, 1'b0, 2'b01};

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_shift <= '0;
      end else begin
         case (state)
            ST_CAP_IR: ir_shift <= cap_pat;
            ST_SH_IR:  ir_shift <= {tdi, ir_shift[IR_W-1:1]};
            default:   ir_shift <= ir_shift;
         endcase
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                 ir <= OP_IDCODE;
      else if (state == ST_RESET)  ir <= OP_IDCODE;
      else if (state == ST_UPD_IR) ir <= ir_shift;
   end

   // R4
   reset_ident_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_RESET) |=> (ir == OP_IDCODE));

   // R2
   ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
   import tap_pkg::*;
#(
   parameter int              N_OUT   = 4,
   parameter int              N_IN    = 3,
   parameter logic [3:0]      VERSION = 4'h0,
   parameter logic [7:0]      FAMILY  = 8'h00,
   parameter logic [7:0]      PRODUCT = 8'h00,
   parameter logic [10:0]     COMPANY = 11'h000,
   localparam int             CHAIN_W = 2 * N_OUT + N_IN
)(
   input  logic               tck,
   input  logic               trst_n,
   input  tap_state_t         state,
   input  dr_sel_t            sel,
   input  logic               tdi,
   input  logic               user_code_vld,
   input  logic [WORD_W-1:0]  user_code,
   input  logic [N_OUT-1:0]   obs_out,
   input  logic [N_OUT-1:0]   obs_oe,
   input  logic [N_IN-1:0]    obs_in,
   output logic               dr_lsb,
   output logic [CHAIN_W-1:0] chain_upd
);

   localparam logic [WORD_W-1:0] ID_WORD = {VERSION, FAMILY, PRODUCT, COMPANY, 1'b1};

   logic                bypass_q;
   logic [WORD_W-1:0]   word_sr;
   logic [WORD_W-1:0]   word_cap;
   logic [CHAIN_W-1:0]  chain_sr;
   logic [CHAIN_W-1:0]  chain_cap;

   initial begin : dr_param_chk
      assert (N_OUT >= 1 && N_IN >= 1) else $error("chain needs at least one pin of each kind");
      assert (CHAIN_W <= 256) else $error("boundary chain too long");
   end

   for (genvar j = 0; j < N_OUT; j++) begin : g_out_cell
      assign chain_cap[2*j]   = obs_oe[j];
      assign chain_cap[2*j+1] = obs_out[j];
   end
   for (genvar k = 0; k < N_IN; k++) begin : g_in_cell
      assign chain_cap[2*N_OUT+k] = obs_in[k];
   end

   assign word_cap = (sel == DR_IDENT) ? ID_WORD :
                     (user_code_vld ? user_code : '1);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         bypass_q <= 1'b0;
         word_sr  <= '0;
         chain_sr <= '0;
      end else begin
         case (sel)
            DR_BYPASS: begin
               if (state == ST_CAP_DR)     bypass_q <= 1'b0;
               else if (state == ST_SH_DR) bypass_q <= tdi;
            end
            DR_IDENT, DR_USER: begin
               if (state == ST_CAP_DR)     word_sr <= word_cap;
               else if (state == ST_SH_DR) word_sr <= {tdi, word_sr[WORD_W-1:1]};
            end
            default: begin
               if (state == ST_CAP_DR)     chain_sr <= chain_cap;
               else if (state == ST_SH_DR) chain_sr <= {tdi, chain_sr[CHAIN_W-1:1]};
            end
         endcase
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                                     chain_upd <= '0;
      else if (state == ST_UPD_DR && sel == DR_CHAIN)  chain_upd <= chain_sr;
   end

   always_comb begin
      case (sel)
         DR_BYPASS:        dr_lsb = bypass_q;
         DR_IDENT, DR_USER: dr_lsb = word_sr[0];
         default:          dr_lsb = chain_sr[0];
      endcase
   end

   // R3
   bypass_zero_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_CAP_DR && sel == DR_BYPASS) |=> (bypass_q == 1'b0));

   // R7
   upd_stable_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state != ST_UPD_DR) |=> $stable(chain_upd));

endmodule

// File: rtl/cfg_mem_tap.sv
module cfg_mem_tap
   import tap_pkg::*;
#(
   parameter int          N_OUT        = 4,
   parameter int          N_IN         = 3,
   parameter int          PULSE_CYCLES = 8,
   parameter logic [3:0]  VERSION      = 4'h0,
   parameter logic [7:0]  FAMILY       = 8'h5A,
   parameter logic [7:0]  PRODUCT      = 8'h17,
   parameter logic [10:0] COMPANY      = 11'h24C
)(
   input  logic              tck,
   input  logic              trst_n,
   input  logic              tms,
   input  logic              tdi,
   input  logic              isp_active,
   input  logic              secure_set,
   input  logic              user_code_vld,
   input  logic [31:0]       user_code,
   input  logic [N_OUT-1:0]  core_out,
   input  logic [N_OUT-1:0]  core_oe,
   input  logic [N_IN-1:0]   pad_in,
   output logic [N_OUT-1:0]  pad_out,
   output logic [N_OUT-1:0]  pad_oe,
   output logic              tdo,
   output logic              tdo_oe,
   output logic              cfg_req_n
);

   localparam int CHAIN_W = 2 * N_OUT + N_IN;
   localparam int CNT_W   = $clog2(PULSE_CYCLES + 1);
   localparam int RUN_W   = CNT_W + 1;

   tap_state_t         state;
   logic [IR_W-1:0]    ir_shift;
   logic [IR_W-1:0]    ir;
   dr_sel_t            sel;
   logic               dr_lsb;
   logic [CHAIN_W-1:0] chain_upd;
   logic [CNT_W-1:0]   pulse_cnt;
   logic               tdo_q;
   logic               tdo_oe_q;
   logic               drive_from_chain;
   logic               float_all;

   initial begin : top_param_chk
      assert (PULSE_CYCLES >= 1) else $error("configure pulse must last at least one cycle");
   end

   tap_fsm i_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .state  (state)
   );

   tap_ir i_ir (
      .tck        (tck),
      .trst_n     (trst_n),
      .state      (state),
      .tdi        (tdi),
      .isp_active (isp_active),
      .secure_set (secure_set),
      .ir_shift   (ir_shift),
      .ir         (ir)
   );

   always_comb begin
      case (ir)
         OP_EXTEST, OP_SAMPLE: sel = DR_CHAIN;
         OP_IDCODE:            sel = DR_IDENT;
         OP_USERCODE:          sel = DR_USER;
         default:              sel = DR_BYPASS;
      endcase
   end

   assign drive_from_chain = (ir == OP_EXTEST) || (ir == OP_CLAMP);
   assign float_all        = (ir == OP_HIGHZ);

   for (genvar j = 0; j < N_OUT; j++) begin : g_pad
      assign pad_out[j] = drive_from_chain ? chain_upd[2*j+1] : core_out[j];
      assign pad_oe[j]  = float_all ? 1'b0 :
                          (drive_from_chain ? chain_upd[2*j] : core_oe[j]);
   end

   tap_dr #(
      .N_OUT   (N_OUT),
      .N_IN    (N_IN),
      .VERSION (VERSION),
      .FAMILY  (FAMILY),
      .PRODUCT (PRODUCT),
      .COMPANY (COMPANY)
   ) i_dr (
      .tck           (tck),
      .trst_n        (trst_n),
      .state         (state),
      .sel           (sel),
      .tdi           (tdi),
      .user_code_vld (user_code_vld),
      .user_code     (user_code),
      .obs_out       (pad_out),
      .obs_oe        (pad_oe),
      .obs_in        (pad_in),
      .dr_lsb        (dr_lsb),
      .chain_upd     (chain_upd)
   );

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)
         pulse_cnt <= '0;
      else if (state == ST_UPD_IR && ir_shift == OP_CONFIG)
         pulse_cnt <= CNT_W'(PULSE_CYCLES);
      else if (pulse_cnt != '0)
         pulse_cnt <= pulse_cnt - 1'b1;
   end

   assign cfg_req_n = (pulse_cnt == '0);

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo_q    <= 1'b0;
         tdo_oe_q <= 1'b0;
      end else begin
         tdo_oe_q <= (state == ST_SH_IR) || (state == ST_SH_DR);
         tdo_q    <= (state == ST_SH_IR) ? ir_shift[0] : dr_lsb;
      end
   end

   assign tdo    = tdo_q;
   assign tdo_oe = tdo_oe_q;

   logic [RUN_W-1:0] low_run;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)        low_run <= '0;
      else if (cfg_req_n) low_run <= '0;
      else                low_run <= low_run + 1'b1;
   end

   // R11
   tdo_enable_chk: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));

   // R10
   pulse_start_chk: assert property (@(posedge tck) disable iff (!trst_n)
      $fell(cfg_req_n) |-> ($past(state) == ST_UPD_IR));

   // R10
   pulse_len_chk: assert property (@(posedge tck) disable iff (!trst_n)
      low_run <= RUN_W'(PULSE_CYCLES));

endmodule

// File: tb/test_cfg_mem_tap.sv
module test_cfg_mem_tap;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int NO = 3;
   localparam int NI = 2;
   localparam int BW = 2 * NO + NI;
   localparam int PULSE = 5;
   localparam logic [3:0]  VER = 4'h3;
   localparam logic [7:0]  FAM = 8'h5A;
   localparam logic [7:0]  PRD = 8'h17;
   localparam logic [10:0] CMP = 11'h24C;
   localparam logic [31:0] ID_EXP = {VER, FAM, PRD, CMP, 1'b1};

   logic          tck = 1'b0;
   logic          trst_n, tms, tdi, isp_active, secure_set, user_code_vld;
   logic [31:0]   user_code;
   logic [NO-1:0] core_out, core_oe, pad_out, pad_oe;
   logic [NI-1:0] pad_in;
   logic          tdo, tdo_oe, cfg_req_n;

   int n_chk = 0;
   int n_fail = 0;
   logic rise_tdo;
   logic [BW-1:0] model_upd;

   always #2.5 tck = ~tck;

   cfg_mem_tap #(
      .N_OUT(NO), .N_IN(NI), .PULSE_CYCLES(PULSE),
      .VERSION(VER), .FAMILY(FAM), .PRODUCT(PRD), .COMPANY(CMP)
   ) i_cfg_mem_tap (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
      .isp_active(isp_active), .secure_set(secure_set),
      .user_code_vld(user_code_vld), .user_code(user_code),
      .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe),
      .tdo(tdo), .tdo_oe(tdo_oe), .cfg_req_n(cfg_req_n)
   );

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d);
      tms = m;
      tdi = d;
      @(posedge tck);
      #1 rise_tdo = tdo;
      @(negedge tck);
      #1;
   endtask

   task automatic scan_ir(input logic [7:0] op, output logic [7:0] cap);
      step(1, 1); step(1, 1); step(0, 1); step(0, 1);
      for (int i = 0; i < 8; i++) begin
         cap[i] = tdo;
         step(i == 7, op[i]);
      end
      step(1, 1); step(0, 1);
   endtask

   task automatic scan_dr(input int len, output logic [63:0] got, output bit edge_ok, output bit oe_ok);
      got = '0;
      edge_ok = 1'b1;
      step(1, 1); step(0, 1); step(0, 1);
      oe_ok = (tdo_oe === 1'b1);
      for (int i = 0; i <= len; i++) begin
         got[i] = tdo;
         step(i == len, 1'b1);
         if (rise_tdo !== got[i]) edge_ok = 1'b0;
      end
      step(1, 1); step(0, 1);
      if (tdo_oe !== 1'b0) oe_ok = 1'b0;
   endtask

   function automatic logic [2*NO-1:0] exp_pads(input logic [7:0] op);
      logic [NO-1:0] o, e;
      for (int j = 0; j < NO; j++) begin
         if (op == 8'h00 || op == 8'hFA) begin
            o[j] = model_upd[2*j+1];
            e[j] = model_upd[2*j];
         end else begin
            o[j] = core_out[j];
            e[j] = (op == 8'hFC) ? 1'b0 : core_oe[j];
         end
      end
      return {e, o};
   endfunction

   function automatic logic [BW-1:0] exp_chain(input logic [7:0] op);
      logic [2*NO-1:0] p;
      logic [BW-1:0] c;
      p = exp_pads(op);
      for (int j = 0; j < NO; j++) begin
         c[2*j]   = p[NO+j];
         c[2*j+1] = p[j];
      end
      for (int k = 0; k < NI; k++) c[2*NO+k] = pad_in[k];
      return c;
   endfunction

   initial begin
      repeat (150000) @(posedge tck);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 1, 0);
      report();
   end

   initial begin
      logic [7:0]  cap;
      logic [63:0] got, exp;
      bit          eok, ook;
      int          len, cnt;

      trst_n = 1'b0; tms = 1'b1; tdi = 1'b1;
      isp_active = 1'b0; secure_set = 1'b0;
      user_code_vld = 1'b0; user_code = '0;
      core_out = 3'b101; core_oe = 3'b110; pad_in = 2'b10;
      model_upd = '0;
      repeat (3) @(negedge tck);
      #1;
      chk(tdo_oe === 1'b0, "R11 reset tdo_oe", 64'(tdo_oe), 0);
      chk(cfg_req_n === 1'b1, "R10 reset cfg_req_n", 64'(cfg_req_n), 1);
      chk({pad_oe, pad_out} === exp_pads(8'hFE), "R8 reset pads", 64'({pad_oe, pad_out}), 64'(exp_pads(8'hFE)));
      trst_n = 1'b1;
      step(0, 1);
      scan_dr(32, got, eok, ook);
      chk(got[32:0] === {1'b1, ID_EXP}, "R4 R5 ident after reset", got, {31'd0, 1'b1, ID_EXP});
      chk(eok, "R11 tdo stable at rising edge", 64'(eok), 1);
      chk(ook, "R11 tdo_oe only while shifting", 64'(ook), 1);

      // Sweep all opcodes: R2 R3 R5 R6 R7 R8 R9 R10 R12
      for (int op = 0; op < 256; op++) begin
         logic [7:0] o8;
         o8 = 8'(op);
         isp_active = o8[3];
         secure_set = o8[4];
         user_code_vld = o8[5];
         user_code = 32'h1234_5678 ^ {24'd0, o8};
         scan_ir(o8, cap);
         chk(cap === {3'b000, o8[3], o8[4], 1'b0, 2'b01}, "R2 capture pattern", 64'(cap),
             64'({3'b000, o8[3], o8[4], 1'b0, 2'b01}));
         chk({pad_oe, pad_out} === exp_pads(o8), "R8 R9 pad drive", 64'({pad_oe, pad_out}),
             64'(exp_pads(o8)));
         chk(cfg_req_n === (o8 != 8'hEE), "R10 configure line after update", 64'(cfg_req_n),
             64'(o8 != 8'hEE));
         if (o8 == 8'hEE) begin
            cnt = 0;
            while (cfg_req_n === 1'b0 && cnt < 100) begin
               cnt++;
               step(0, 1);
            end
            chk(cnt == PULSE, "R10 pulse length", 64'(cnt), 64'(PULSE));
         end
         if (o8 == 8'h00 || o8 == 8'h01) begin
            len = BW;
            exp = 64'(exp_chain(o8));
         end else if (o8 == 8'hFE) begin
            len = 32;
            exp = 64'(ID_EXP);
         end else if (o8 == 8'hFD) begin
            len = 32;
            exp = user_code_vld ? 64'(user_code) : 64'h0000_0000_FFFF_FFFF;
         end else begin
            len = 1;
            exp = 0;
         end
         scan_dr(len, got, eok, ook);
         got = got & ~(64'hFFFF_FFFF_FFFF_FFFF << (len + 1));
         exp = exp | (64'd1 << len);
         chk(got === exp, "R3 R5 R6 R7 R12 DR capture and length", got, exp);
         if (o8 == 8'h00 || o8 == 8'h01) model_upd = '1;
      end

      // R7 update register now all ones: EXTEST drives from it
      scan_ir(8'h00, cap);
      chk({pad_oe, pad_out} === {NO{2'b11}}, "R7 R8 update register drives pads", 64'({pad_oe, pad_out}),
          64'({NO{2'b11}}));

      // R6 unprogrammed user code
      scan_ir(8'hFD, cap);
      user_code_vld = 1'b0;
      user_code = 32'h0BAD_F00D;
      scan_dr(32, got, eok, ook);
      chk(got[32:0] === {1'b1, 32'hFFFF_FFFF}, "R6 blank user code", got, 64'h1_FFFF_FFFF);

      // R1 R4 five ones from Shift-DR reach reset, IDCODE restored
      scan_ir(8'hFF, cap);
      step(1, 1); step(0, 1); step(0, 1);
      for (int i = 0; i < 5; i++) step(1, 1);
      step(0, 1);
      scan_dr(32, got, eok, ook);
      chk(got[32:0] === {1'b1, ID_EXP}, "R1 R4 tms reset restores ident", got, {31'd0, 1'b1, ID_EXP});

      // R10 asynchronous reset releases the configure line
      scan_ir(8'hEE, cap);
      chk(cfg_req_n === 1'b0, "R10 pulse started", 64'(cfg_req_n), 0);
      trst_n = 1'b0;
      #1;
      chk(cfg_req_n === 1'b1, "R10 reset releases pulse", 64'(cfg_req_n), 1);
      chk({pad_oe, pad_out} === exp_pads(8'hFE), "R1 R8 reset pads", 64'({pad_oe, pad_out}),
          64'(exp_pads(8'hFE)));
      @(negedge tck);
      #1 trst_n = 1'b1;
      step(0, 1);
      report();
   end

endmodule